// File: doc/BRIEF.md
# Near Relative Branch Resolver

This unit settles the outcome of a 16-bit near relative control transfer for a segmented core. When the issuing stage pulses `start`, the unit samples an operation code, the five arithmetic flags, the address of the following instruction, a signed displacement, the count register, an address-size bit and the code segment limit. One clock later it pulses `done` and presents whether the branch went, the IP to fetch from next, a general-protection fault indication and, for the counting loop forms, a write of the updated count register.

The target is the sequential IP plus the displacement, wrapped to 16 bits. A branch that would land above the code segment limit is not taken. It raises the fault, leaves the IP output where it was, and also suppresses the count decrement, so the architectural state matches the state before the instruction. A branch that is not taken can never fault.

Top module: `near_branch_resolve`

## Requirements
- R1: After reset `done`, `taken`, `gpFault` and `cntWe` are 0 and `nextIp` and `cntNew` are 0. Every result appears, with `done` high, exactly one clock after the `start` cycle. `done` lasts one cycle.
- R2: The branch target is `seqIp + disp` modulo 2^16. A taken branch sets `taken`=1 and `nextIp` to the target.
- R3: Codes 0 to 15 are flag conditions. The code divided by two selects the condition: 0 OF, 1 CF, 2 ZF, 3 CF or ZF, 4 SF, 5 PF, 6 SF xor OF, 7 ZF or (SF xor OF). Code bit 0 set inverts the condition.
- R4: A branch that is not taken gives `taken`=0, `gpFault`=0 and `nextIp`=`seqIp`, even when its target lies beyond the limit.
- R5: A branch whose condition holds and whose target is greater than `csLimit` gives `gpFault`=1 and `taken`=0, and `nextIp` keeps its previous value. A target equal to the limit is allowed.
- R6: Code 16 is an unconditional jump.
- R7: Code 17 branches when the selected count (see R10) is zero. It never asserts `cntWe`.
- R8: Code 18 decrements the selected count and branches when the result is nonzero. `cntWe` is high in the `done` cycle whether or not the branch is taken, and `cntNew` carries the new register value.
- R9: Code 19 also requires ZF=1 to branch and code 20 requires ZF=0. Both write the count exactly as in R8.
- R10: When `addrWide`=1 the full 32-bit count is used. When `addrWide`=0 only bits 15:0 are tested and decremented, wrapping from 0 to FFFF, and `cntNew[31:16]` equals `countIn[31:16]`.
- R11: A limit fault on a loop code suppresses the count write (`cntWe`=0).
- R12: Codes 21 to 31 complete as not taken, with no fault and no count write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Sample inputs and resolve |
| opCode | input | 5 | Operation code (R3, R6 to R9, R12) |
| flagCf | input | 1 | Carry flag |
| flagZf | input | 1 | Zero flag |
| flagSf | input | 1 | Sign flag |
| flagOf | input | 1 | Overflow flag |
| flagPf | input | 1 | Parity flag |
| seqIp | input | 16 | IP of the following instruction |
| disp | input | 16 | Signed displacement |
| countIn | input | 32 | Current count register |
| addrWide | input | 1 | 1 selects the 32-bit count, 0 the 16-bit count |
| csLimit | input | 16 | Code segment limit |
| done | output | 1 | Result valid pulse |
| taken | output | 1 | Branch transferred control |
| nextIp | output | 16 | IP to fetch from |
| gpFault | output | 1 | General-protection fault (error code 0) |
| cntWe | output | 1 | Count register write enable |
| cntNew | output | 32 | New count register value |

## Verification
The loop codes are the only place where the count decrement and the limit check resolve in the same cycle, and the fault must cancel the write. The bench issues loop operations whose targets fall beyond the limit, once with a count that makes the branch go and once with a count that makes it fall through. In the first case it expects a fault with no write and an unchanged IP. In the second it expects a normal write with no fault, because a branch that is not taken is never checked against the limit.

// File: rtl/nbr_pkg.sv
package nbr_pkg;

  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_JMP    = 5'd16,
    OP_JCZ    = 5'd17,
    OP_LOOP   = 5'd18,
    OP_LOOPZ  = 5'd19,
    OP_LOOPNZ = 5'd20
  } nbr_op_e;

  // strobes from control to datapath, valid in the start cycle
  typedef struct packed {
    logic capture;
    logic loadTarget;
    logic loadSeq;
    logic raiseFault;
    logic writeCnt;
  } nbr_strobe_t;

endpackage

// File: rtl/nbr_ctrl.sv
module nbr_ctrl
  import nbr_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [OP_W-1:0] opCode,
  input  logic            flagCf,
  input  logic            flagZf,
  input  logic            flagSf,
  input  logic            flagOf,
  input  logic            flagPf,
  input  logic            cntIsZero,
  input  logic            decIsZero,
  input  logic            overLimit,
  output nbr_strobe_t     strobes,
  output logic            done
);

  logic condBase;
  logic condFlag;
  logic isFlagOp;
  logic isLoopOp;
  logic wantBranch;
  logic faultHit;

  // flag condition: upper code bits pick the test, bit 0 inverts
  always_comb begin
    case (opCode[3:1])
      3'd0:    condBase = flagOf;
      3'd1:    condBase = flagCf;
      3'd2:    condBase = flagZf;
      3'd3:    condBase = flagCf | flagZf;
      3'd4:    condBase = flagSf;
      3'd5:    condBase = flagPf;
      3'd6:    condBase = flagSf ^ flagOf;
      default: condBase = flagZf | (flagSf ^ flagOf);
    endcase
    condFlag = condBase ^ opCode[0];
  end

  assign isFlagOp = (opCode[OP_W-1] == 1'b0);

  always_comb begin
    wantBranch = 1'b0;
    isLoopOp   = 1'b0;
    if (isFlagOp) begin
      wantBranch = condFlag;
    end else begin
      case (opCode)
        OP_JMP:    wantBranch = 1'b1;
        OP_JCZ:    wantBranch = cntIsZero;
        OP_LOOP: begin
          isLoopOp   = 1'b1;
          wantBranch = !decIsZero;
        end
        OP_LOOPZ: begin
          isLoopOp   = 1'b1;
          wantBranch = !decIsZero && flagZf;
        end
        OP_LOOPNZ: begin
          isLoopOp   = 1'b1;
          wantBranch = !decIsZero && !flagZf;
        end
        default: begin
          isLoopOp   = 1'b0;
          wantBranch = 1'b0;
        end
      endcase
    end
  end

  assign faultHit = wantBranch && overLimit;

  always_comb begin
    strobes.capture    = start;
    strobes.loadTarget = start && wantBranch && !overLimit;
    strobes.loadSeq    = start && !wantBranch;
    strobes.raiseFault = start && faultHit;
    strobes.writeCnt   = start && isLoopOp && !faultHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) done <= 1'b0;
    else       done <= start;
  end

endmodule

// File: rtl/nbr_datapath.sv
module nbr_datapath
  import nbr_pkg::*;
#(
  parameter int IP_W     = 16,
  parameter int CNT_W    = 32,
  parameter int NARROW_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  nbr_strobe_t      strobes,
  input  logic [IP_W-1:0]  seqIp,
  input  logic [IP_W-1:0]  disp,
  input  logic [CNT_W-1:0] countIn,
  input  logic             addrWide,
  input  logic [IP_W-1:0]  csLimit,
  output logic             cntIsZero,
  output logic             decIsZero,
  output logic             overLimit,
  output logic             taken,
  output logic [IP_W-1:0]  nextIp,
  output logic             gpFault,
  output logic             cntWe,
  output logic [CNT_W-1:0] cntNew
);

  localparam int HIGH_W = CNT_W - NARROW_W;

  logic [IP_W-1:0]     target;
  logic [CNT_W-1:0]    wideDec;
  logic [NARROW_W-1:0] lowDec;
  logic [CNT_W-1:0]    decVal;

  assign target    = seqIp + disp;
  assign overLimit = (target > csLimit);

  assign wideDec = countIn - {{(CNT_W-1){1'b0}}, 1'b1};
  assign lowDec  = countIn[NARROW_W-1:0] - {{(NARROW_W-1){1'b0}}, 1'b1};

  generate
    if (HIGH_W > 0) begin : g_split
      logic [CNT_W-1:0] narrowVal;
      assign narrowVal = {countIn[CNT_W-1:NARROW_W], lowDec};
      assign decVal    = addrWide ? wideDec : narrowVal;
    end else begin : g_flat
      assign decVal = wideDec;
    end
  endgenerate

  assign cntIsZero = addrWide ? (countIn == '0)
                              : (countIn[NARROW_W-1:0] == '0);
  assign decIsZero = addrWide ? (wideDec == '0) : (lowDec == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      taken   <= 1'b0;
      nextIp  <= '0;
      gpFault <= 1'b0;
      cntWe   <= 1'b0;
      cntNew  <= '0;
    end else begin
      cntWe <= strobes.writeCnt;
      if (strobes.writeCnt) cntNew <= decVal;
      if (strobes.capture) begin
        taken   <= strobes.loadTarget;
        gpFault <= strobes.raiseFault;
      end
      if (strobes.loadTarget)   nextIp <= target;
      else if (strobes.loadSeq) nextIp <= seqIp;
    end
  end

endmodule

// File: rtl/near_branch_resolve.sv
module near_branch_resolve
  import nbr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [4:0]  opCode,
  input  logic        flagCf,
  input  logic        flagZf,
  input  logic        flagSf,
  input  logic        flagOf,
  input  logic        flagPf,
  input  logic [15:0] seqIp,
  input  logic [15:0] disp,
  input  logic [31:0] countIn,
  input  logic        addrWide,
  input  logic [15:0] csLimit,
  output logic        done,
  output logic        taken,
  output logic [15:0] nextIp,
  output logic        gpFault,
  output logic        cntWe,
  output logic [31:0] cntNew
);

  nbr_strobe_t strobes;
  logic cntIsZero;
  logic decIsZero;
  logic overLimit;

  nbr_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opCode(opCode),
    .flagCf(flagCf), .flagZf(flagZf), .flagSf(flagSf),
    .flagOf(flagOf), .flagPf(flagPf),
    .cntIsZero(cntIsZero), .decIsZero(decIsZero), .overLimit(overLimit),
    .strobes(strobes), .done(done)
  );

  nbr_datapath #(.IP_W(16), .CNT_W(32), .NARROW_W(16)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .seqIp(seqIp), .disp(disp), .countIn(countIn),
    .addrWide(addrWide), .csLimit(csLimit),
    .cntIsZero(cntIsZero), .decIsZero(decIsZero), .overLimit(overLimit),
    .taken(taken), .nextIp(nextIp), .gpFault(gpFault),
    .cntWe(cntWe), .cntNew(cntNew)
  );

endmodule

// File: rtl/nbr_checker.sv
module nbr_checker (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic [4:0]  opCode,
  input logic [15:0] seqIp,
  input logic [31:0] countIn,
  input logic        addrWide,
  input logic [15:0] csLimit,
  input logic        done,
  input logic        taken,
  input logic [15:0] nextIp,
  input logic        gpFault,
  input logic        cntWe,
  input logic [31:0] cntNew
);

  a_r1_done_follows_start: assert property (@(posedge clk) disable iff (!rstN)
    start |=> done);

  a_r1_done_needs_start: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(start));

  a_r5_fault_keeps_ip: assert property (@(posedge clk) disable iff (!rstN)
    (done && gpFault) |-> $stable(nextIp));

  a_r5_taken_within_limit: assert property (@(posedge clk) disable iff (!rstN)
    (done && taken) |-> (nextIp <= $past(csLimit)));

  a_r5_fault_not_taken: assert property (@(posedge clk) disable iff (!rstN)
    !(taken && gpFault));

  a_r4_fallthrough_seq: assert property (@(posedge clk) disable iff (!rstN)
    (done && !taken && !gpFault) |-> (nextIp == $past(seqIp)));

  a_r7_jcz_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (start && opCode == 5'd17) |=> !cntWe);

  a_r11_fault_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (done && gpFault) |-> !cntWe);

  a_r10_upper_kept: assert property (@(posedge clk) disable iff (!rstN)
    (start && !addrWide && opCode >= 5'd18 && opCode <= 5'd20)
      |=> (!cntWe || cntNew[31:16] == $past(countIn[31:16])));

  a_r12_reserved_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (start && opCode > 5'd20) |=> (!taken && !gpFault && !cntWe));

endmodule

bind near_branch_resolve nbr_checker u_nbr_checker (
  .clk(clk), .rstN(rstN), .start(start), .opCode(opCode),
  .seqIp(seqIp), .countIn(countIn), .addrWide(addrWide), .csLimit(csLimit),
  .done(done), .taken(taken), .nextIp(nextIp), .gpFault(gpFault),
  .cntWe(cntWe), .cntNew(cntNew)
);

// File: tb/test_near_branch_resolve.sv
module test_near_branch_resolve;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  opCode = '0;
  logic        flagCf = 0, flagZf = 0, flagSf = 0, flagOf = 0, flagPf = 0;
  logic [15:0] seqIp = '0, disp = '0, csLimit = '0;
  logic [31:0] countIn = '0;
  logic        addrWide = 1'b0;
  logic        done, taken, gpFault, cntWe;
  logic [15:0] nextIp;
  logic [31:0] cntNew;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  near_branch_resolve i_near_branch_resolve (
    .clk(clk), .rstN(rstN), .start(start), .opCode(opCode),
    .flagCf(flagCf), .flagZf(flagZf), .flagSf(flagSf), .flagOf(flagOf),
    .flagPf(flagPf), .seqIp(seqIp), .disp(disp), .countIn(countIn),
    .addrWide(addrWide), .csLimit(csLimit), .done(done), .taken(taken),
    .nextIp(nextIp), .gpFault(gpFault), .cntWe(cntWe), .cntNew(cntNew)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic condModel(logic [4:0] c, logic [4:0] f);
    // f = {PF, OF, SF, ZF, CF}
    logic r;
    case (c[3:1])
      3'd0: r = f[3];
      3'd1: r = f[0];
      3'd2: r = f[1];
      3'd3: r = f[0] | f[1];
      3'd4: r = f[2];
      3'd5: r = f[4];
      3'd6: r = f[2] ^ f[3];
      default: r = f[1] | (f[2] ^ f[3]);
    endcase
    return r ^ c[0];
  endfunction

  task automatic issue(logic [4:0] op, logic [4:0] f, logic [15:0] ip,
                       logic [15:0] d, logic [31:0] cnt, logic wide,
                       logic [15:0] lim);
    @(negedge clk);
    opCode = op; {flagPf, flagOf, flagSf, flagZf, flagCf} = f;
    seqIp = ip; disp = d; countIn = cnt; addrWide = wide; csLimit = lim;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    checks++;
    if (done !== 1'b1) begin
      errors++;
      $display("FAIL R1 done actual=%b expected=1", done);
    end
  endtask

  task automatic tReset();
    check("R1 done", done, 0);
    check("R1 taken", taken, 0);
    check("R1 nextIp", nextIp, 0);
    check("R1 gpFault", gpFault, 0);
    check("R1 cntWe", cntWe, 0);
    check("R1 cntNew", cntNew, 0);
  endtask

  task automatic tJump();
    issue(5'd16, 5'b0, 16'h1000, 16'h0010, 0, 0, 16'hFFFF);
    check("R6 taken", taken, 1);
    check("R2 target", nextIp, 16'h1010);
    issue(5'd16, 5'b0, 16'hFFF0, 16'h0020, 0, 0, 16'hFFFF);
    check("R2 wrap", nextIp, 16'h0010);
    issue(5'd16, 5'b0, 16'h0100, 16'hFFF0, 0, 0, 16'hFFFF);
    check("R2 negative disp", nextIp, 16'h00F0);
    @(negedge clk);
    check("R1 done one cycle", done, 0);
  endtask

  task automatic tConditions();
    logic [4:0] pats [8] = '{5'b00000, 5'b11111, 5'b00001, 5'b00010,
                             5'b00100, 5'b01100, 5'b01000, 5'b10000};
    for (int p = 0; p < 8; p++) begin
      for (int c = 0; c < 16; c++) begin
        logic exp;
        exp = condModel(5'(c), pats[p]);
        issue(5'(c), pats[p], 16'h2000, 16'h0040, 0, 0, 16'hFFFF);
        check("R3 taken", taken, exp);
        check("R3 nextIp", nextIp, exp ? 16'h2040 : 16'h2000);
      end
    end
  endtask

  task automatic tLimit();
    issue(5'd16, 5'b0, 16'h0100, 16'h0100, 0, 0, 16'h0300);
    check("R5 inside", nextIp, 16'h0200);
    issue(5'd16, 5'b0, 16'h0200, 16'h0100, 0, 0, 16'h0300);
    check("R5 equal limit taken", taken, 1);
    check("R5 equal limit ip", nextIp, 16'h0300);
    issue(5'd16, 5'b0, 16'h0200, 16'h0101, 0, 0, 16'h0300);
    check("R5 fault", gpFault, 1);
    check("R5 fault not taken", taken, 0);
    check("R5 ip held", nextIp, 16'h0300);
    issue(5'd4, 5'b00000, 16'h0200, 16'h0400, 0, 0, 16'h0300);
    check("R4 no fault", gpFault, 0);
    check("R4 seq ip", nextIp, 16'h0200);
    check("R4 not taken", taken, 0);
  endtask

  task automatic tCountZero();
    issue(5'd17, 5'b0, 16'h0500, 16'h0008, 32'hABCD0000, 0, 16'hFFFF);
    check("R7 narrow zero taken", taken, 1);
    check("R7 no write", cntWe, 0);
    issue(5'd17, 5'b0, 16'h0500, 16'h0008, 32'hABCD0000, 1, 16'hFFFF);
    check("R7 wide nonzero", taken, 0);
    issue(5'd17, 5'b0, 16'h0500, 16'h0008, 32'h0, 1, 16'hFFFF);
    check("R7 wide zero taken", nextIp, 16'h0508);
  endtask

  task automatic tLoop();
    issue(5'd18, 5'b0, 16'h0600, 16'hFFFC, 32'h12340003, 0, 16'hFFFF);
    check("R8 taken", taken, 1);
    check("R8 cntWe", cntWe, 1);
    check("R10 narrow dec", cntNew, 32'h12340002);
    @(negedge clk);
    check("R8 cntWe pulse", cntWe, 0);
    issue(5'd18, 5'b0, 16'h0600, 16'hFFFC, 32'h12340001, 0, 16'hFFFF);
    check("R8 reach zero not taken", taken, 0);
    check("R8 write anyway", cntWe, 1);
    check("R8 new value", cntNew, 32'h12340000);
    issue(5'd18, 5'b0, 16'h0600, 16'hFFFC, 32'h12340000, 0, 16'hFFFF);
    check("R10 narrow wrap", cntNew, 32'h1234FFFF);
    check("R10 wrap taken", taken, 1);
    issue(5'd18, 5'b0, 16'h0600, 16'hFFFC, 32'h00010000, 1, 16'hFFFF);
    check("R10 wide borrow", cntNew, 32'h0000FFFF);
    check("R10 wide taken", taken, 1);
    issue(5'd19, 5'b00000, 16'h0600, 16'h0004, 32'h5, 1, 16'hFFFF);
    check("R9 loopz zf0", taken, 0);
    check("R9 loopz write", cntNew, 32'h4);
    issue(5'd19, 5'b00010, 16'h0600, 16'h0004, 32'h5, 1, 16'hFFFF);
    check("R9 loopz zf1", taken, 1);
    issue(5'd20, 5'b00000, 16'h0600, 16'h0004, 32'h5, 1, 16'hFFFF);
    check("R9 loopnz zf0", taken, 1);
    issue(5'd20, 5'b00010, 16'h0600, 16'h0004, 32'h5, 1, 16'hFFFF);
    check("R9 loopnz zf1", taken, 0);
    check("R9 loopnz write", cntWe, 1);
  endtask

  task automatic tLoopFault();
    issue(5'd16, 5'b0, 16'h0000, 16'h0040, 0, 0, 16'h0100);
    issue(5'd18, 5'b0, 16'h0080, 16'h0100, 32'h5, 1, 16'h0100);
    check("R11 fault", gpFault, 1);
    check("R11 no write", cntWe, 0);
    check("R11 ip held", nextIp, 16'h0040);
    issue(5'd18, 5'b0, 16'h0080, 16'h0100, 32'h1, 1, 16'h0100);
    check("R11 fallthrough no fault", gpFault, 0);
    check("R11 fallthrough write", cntWe, 1);
    check("R11 fallthrough value", cntNew, 32'h0);
  endtask

  task automatic tReserved();
    issue(5'd25, 5'b11111, 16'h0700, 16'h0010, 32'h3, 1, 16'h0000);
    check("R12 not taken", taken, 0);
    check("R12 no fault", gpFault, 0);
    check("R12 no write", cntWe, 0);
    check("R12 seq ip", nextIp, 16'h0700);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tJump();
    tConditions();
    tLimit();
    tCountZero();
    tLoop();
    tLoopFault();
    tReserved();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule